// File: doc/BRIEF.md
# DMA Channel Control Register Bank

This block is the software-visible control store of a 32-channel DMA controller. A simple 32-bit bus (address, write enable, write data and combinational read data) reaches a small register space. That space holds the global configuration, a status word, the control table base pointer and five per-channel attribute vectors. The attributes are enable, request mask, burst-only, alternate-structure select and high priority.

Software never rewrites an attribute vector whole. Each vector has a write-one-to-set register and a write-one-to-clear register, so one channel can be changed without a read-modify-write race against other users.

The bank also turns one-shot software requests and the raw peripheral request lines into the qualified per-channel request vector that the transfer engine consumes. Peripheral requests are filtered by the request mask. Software requests bypass the mask. Both are gated by the channel enable and by the master enable.

A sticky bus-error flag is set by an error pulse from the engine and is cleared by software.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, all five attribute vectors are 0, the master enable is 0, the control base pointer is 0, the error flag is 0 and no qualified request is active.
- R2: Writing to a set register (burst-only 0x018, request mask 0x020, enable 0x028, alternate select 0x030, high priority 0x038) sets each vector bit that is written as 1. Bits written as 0 stay unchanged. The other four vectors are not affected.
- R3: Writing to a clear register (burst-only 0x01C, request mask 0x024, enable 0x02C, alternate select 0x034, high priority 0x03C) clears each vector bit that is written as 1. Bits written as 0 stay unchanged.
- R4: Reading either register of a set/clear pair returns the current vector. Reading the software request register (0x014) returns 0.
- R5: Bit 0 of the configuration register (0x004) is the master enable and reads back. The status word (0x000) reads the master enable at bit 0, the `engine_state` input at bits 7:4 and NUM_CH-1 (31) at bits 20:16, with all other bits 0.
- R6: The control base pointer (0x008) stores only write-data bits 31:10, and its bits 9:0 read as 0. The alternate base pointer (0x00C) reads the control base plus NUM_CH*16 (0x200). Writes to 0x00C and to the status word change nothing.
- R7: A channel whose request-mask bit is 1 never passes its peripheral request. An unmasked, enabled channel passes its peripheral request to `chan_req` in the same cycle, with no register on the path.
- R8: Writing 1 to bit n of 0x014 drives `chan_req[n]` high for exactly one cycle, in the cycle that follows the write edge, whether or not channel n is masked.
- R9: `chan_req[n]` is 0 whenever enable bit n is 0 or the master enable is 0, for both software and peripheral requests.
- R10: An `bus_err_in` pulse sets a sticky error flag that reads at bit 0 of 0x04C. Writing 1 to bit 0 of 0x04C clears the flag, and writing 0 leaves it set. If a set and a clear land in the same cycle, the set wins.
- R11: Offset 0x010 reads the `wait_stat` input. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wen | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| periph_req | input | 32 | Raw peripheral request lines, one per channel |
| wait_stat | input | 32 | Per-channel wait-on-request status from the engine |
| engine_state | input | 4 | Control state machine state from the engine |
| bus_err_in | input | 1 | Bus error pulse from the engine |
| chan_req | output | 32 | Qualified per-channel requests |
| cfg_enable | output | 32 | Channel enable vector |
| cfg_mask | output | 32 | Request mask vector |
| cfg_burst | output | 32 | Burst-only vector |
| cfg_alt | output | 32 | Alternate structure select vector |
| cfg_prio | output | 32 | High priority vector |
| master_en | output | 1 | Controller master enable |
| ctl_base | output | 32 | Control table base address |

## Verification
The bench sweeps every set/clear pair with overlapping bit patterns. It checks the port vector, both read addresses and the other four vectors after each write. This catches a design that writes the whole vector, that treats zeros as clears, or that aliases two pairs.

Request qualification is covered with patterns that place all eight combinations of mask, enable and peripheral request on different channels, under both master-enable states. This exposes a mask applied to software requests, or an enable or master gate that is missing.

Software requests are sampled in the cycle after the write and in the cycle after that. A design whose pulse is late, sticks high or is filtered by the mask fails there. The error flag is checked for a simultaneous set and clear, where the wrong priority loses the error.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;

   localparam int NUM_ATTR = 5;

   typedef enum int {
      ATTR_BURST  = 0,
      ATTR_MASK   = 1,
      ATTR_ENABLE = 2,
      ATTR_ALT    = 3,
      ATTR_PRIO   = 4
   } attr_e;

   localparam logic [11:0] OFS_STATUS  = 12'h000;
   localparam logic [11:0] OFS_CONFIG  = 12'h004;
   localparam logic [11:0] OFS_CTLBASE = 12'h008;
   localparam logic [11:0] OFS_ALTBASE = 12'h00C;
   localparam logic [11:0] OFS_WAIT    = 12'h010;
   localparam logic [11:0] OFS_SWREQ   = 12'h014;
   localparam logic [11:0] OFS_ERRCLR  = 12'h04C;
   localparam logic [11:0] OFS_PAIR0   = 12'h018;

   function automatic logic [11:0] set_ofs(int idx);
      return OFS_PAIR0 + 12'(idx * 8);
   endfunction

   function automatic logic [11:0] clr_ofs(int idx);
      return OFS_PAIR0 + 12'(idx * 8) + 12'h004;
   endfunction

endpackage

// File: rtl/dma_setclr_vec.sv
module dma_setclr_vec #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] vec_o
);

   logic [W-1:0] vec_q;
   logic [W-1:0] set_bits;
   logic [W-1:0] clr_bits;

   always_comb begin
      set_bits = set_we ? wdata : '0;
      clr_bits = clr_we ? wdata : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         vec_q <= '0;
      else if (set_we || clr_we)
         vec_q <= (vec_q | set_bits) & ~clr_bits;
   end

   assign vec_o = vec_q;

endmodule

// File: rtl/dma_glob_regs.sv
module dma_glob_regs #(
   parameter int BASE_LSB = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic               cfg_bit,
   input  logic               base_we,
   input  logic [31:BASE_LSB] base_bits,
   input  logic               errclr_we,
   input  logic               errclr_bit,
   input  logic               err_pulse,
   output logic               master_en,
   output logic [31:0]        ctl_base,
   output logic               err_flag
);

   logic               master_q;
   logic [31:BASE_LSB] base_q;
   logic               err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         master_q <= 1'b0;
         base_q   <= '0;
         err_q    <= 1'b0;
      end else begin
         if (cfg_we)
            master_q <= cfg_bit;
         if (base_we)
            base_q <= base_bits;
         if (err_pulse)
            err_q <= 1'b1;
         else if (errclr_we && errclr_bit)
            err_q <= 1'b0;
      end
   end

   assign master_en = master_q;
   assign ctl_base  = {base_q, {BASE_LSB{1'b0}}};
   assign err_flag  = err_q;

endmodule

// File: rtl/dma_req_qual.sv
module dma_req_qual #(
   parameter int NUM_CH = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_we,
   input  logic [NUM_CH-1:0] sw_bits,
   input  logic [NUM_CH-1:0] periph_req,
   input  logic [NUM_CH-1:0] mask,
   input  logic [NUM_CH-1:0] enable,
   input  logic              master_en,
   output logic [NUM_CH-1:0] sw_pulse,
   output logic [NUM_CH-1:0] chan_req
);

   logic [NUM_CH-1:0] sw_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sw_q <= '0;
      else
         sw_q <= sw_we ? sw_bits : '0;
   end

   genvar c;
   generate
      for (c = 0; c < NUM_CH; c++) begin : g_ch
         logic raw;
         assign raw         = (periph_req[c] & ~mask[c]) | sw_q[c];
         assign chan_req[c] = raw & enable[c] & master_en;
      end
   endgenerate

   assign sw_pulse = sw_q;

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
   import dma_regs_pkg::*;
#(
   parameter int NUM_CH      = 32,
   parameter int ADDR_W      = 12,
   parameter int STATE_W     = 4,
   parameter int BASE_LSB    = 10,
   parameter int ENTRY_BYTES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wen,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [NUM_CH-1:0] periph_req,
   input  logic [NUM_CH-1:0] wait_stat,
   input  logic [STATE_W-1:0] engine_state,
   input  logic              bus_err_in,
   output logic [NUM_CH-1:0] chan_req,
   output logic [NUM_CH-1:0] cfg_enable,
   output logic [NUM_CH-1:0] cfg_mask,
   output logic [NUM_CH-1:0] cfg_burst,
   output logic [NUM_CH-1:0] cfg_alt,
   output logic [NUM_CH-1:0] cfg_prio,
   output logic              master_en
   ,output logic [31:0]      ctl_base
);

   localparam int          ALT_OFS  = NUM_CH * ENTRY_BYTES;
   localparam logic [4:0]  CH_FIELD = 5'(NUM_CH - 1);

   generate
      if (NUM_CH < 1 || NUM_CH > 32) begin : g_bad_ch
         $error("NUM_CH must lie in 1..32");
      end
      if (ADDR_W < 7) begin : g_bad_addr
         $error("ADDR_W too small for the register space");
      end
      if (STATE_W != 4) begin : g_bad_state
         $error("STATE_W must be 4 for the status field");
      end
      if (ALT_OFS >= (1 << BASE_LSB)) begin : g_bad_align
         $error("alternate table does not fit the base alignment");
      end
   endgenerate

   function automatic logic hit(logic [ADDR_W-1:0] a, logic [11:0] ofs);
      return a == ADDR_W'(ofs);
   endfunction

   logic [NUM_ATTR-1:0][NUM_CH-1:0] attr_vec;
   logic [NUM_CH-1:0]               sw_pulse;
   logic                            err_flag;

   genvar g;
   generate
      for (g = 0; g < NUM_ATTR; g++) begin : g_attr
         dma_setclr_vec #(.W(NUM_CH)) u_vec (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_we (bus_wen && hit(bus_addr, set_ofs(g))),
            .clr_we (bus_wen && hit(bus_addr, clr_ofs(g))),
            .wdata  (bus_wdata[NUM_CH-1:0]),
            .vec_o  (attr_vec[g])
         );
      end
   endgenerate

   assign cfg_burst  = attr_vec[ATTR_BURST];
   assign cfg_mask   = attr_vec[ATTR_MASK];
   assign cfg_enable = attr_vec[ATTR_ENABLE];
   assign cfg_alt    = attr_vec[ATTR_ALT];
   assign cfg_prio   = attr_vec[ATTR_PRIO];

   dma_glob_regs #(.BASE_LSB(BASE_LSB)) u_glob (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (bus_wen && hit(bus_addr, OFS_CONFIG)),
      .cfg_bit    (bus_wdata[0]),
      .base_we    (bus_wen && hit(bus_addr, OFS_CTLBASE)),
      .base_bits  (bus_wdata[31:BASE_LSB]),
      .errclr_we  (bus_wen && hit(bus_addr, OFS_ERRCLR)),
      .errclr_bit (bus_wdata[0]),
      .err_pulse  (bus_err_in),
      .master_en  (master_en),
      .ctl_base   (ctl_base),
      .err_flag   (err_flag)
   );

   dma_req_qual #(.NUM_CH(NUM_CH)) u_qual (
      .clk        (clk),
      .rst_n      (rst_n),
      .sw_we      (bus_wen && hit(bus_addr, OFS_SWREQ)),
      .sw_bits    (bus_wdata[NUM_CH-1:0]),
      .periph_req (periph_req),
      .mask       (cfg_mask),
      .enable     (cfg_enable),
      .master_en  (master_en),
      .sw_pulse   (sw_pulse),
      .chan_req   (chan_req)
   );

   always_comb begin
      bus_rdata = '0;
      if (hit(bus_addr, OFS_STATUS)) begin
         bus_rdata[0]     = master_en;
         bus_rdata[7:4]   = engine_state;
         bus_rdata[20:16] = CH_FIELD;
      end else if (hit(bus_addr, OFS_CONFIG)) begin
         bus_rdata[0] = master_en;
      end else if (hit(bus_addr, OFS_CTLBASE)) begin
         bus_rdata = ctl_base;
      end else if (hit(bus_addr, OFS_ALTBASE)) begin
         bus_rdata = ctl_base + 32'(ALT_OFS);
      end else if (hit(bus_addr, OFS_WAIT)) begin
         bus_rdata = 32'(wait_stat);
      end else if (hit(bus_addr, OFS_ERRCLR)) begin
         bus_rdata[0] = err_flag;
      end else begin
         for (int i = 0; i < NUM_ATTR; i++) begin
            if (hit(bus_addr, set_ofs(i)) || hit(bus_addr, clr_ofs(i)))
               bus_rdata = 32'(attr_vec[i]);
         end
      end
   end

endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
   parameter int NUM_CH = 32,
   parameter int ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wen,
   input logic [31:0]       bus_wdata,
   input logic              bus_err_in,
   input logic [NUM_CH-1:0] chan_req,
   input logic [NUM_CH-1:0] cfg_enable,
   input logic [NUM_CH-1:0] cfg_mask,
   input logic              master_en,
   input logic [NUM_CH-1:0] sw_pulse,
   input logic              err_flag
);

   // R2
   enable_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wen && bus_addr == ADDR_W'(12'h028)) |=>
      ((cfg_enable & $past(bus_wdata[NUM_CH-1:0])) == $past(bus_wdata[NUM_CH-1:0])));

   // R3
   mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wen && bus_addr == ADDR_W'(12'h024)) |=>
      ((cfg_mask & $past(bus_wdata[NUM_CH-1:0])) == '0));

   // R2
   enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wen |=> $stable(cfg_enable));

   // R7
   masked_periph_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_req & cfg_mask & ~sw_pulse) == '0);

   // R9
   need_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_req & ~cfg_enable) == '0);

   // R9
   need_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !master_en |-> (chan_req == '0));

   // R8
   sw_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_pulse != '0 && !(bus_wen && bus_addr == ADDR_W'(12'h014))) |=> (sw_pulse == '0));

   // R10
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err_in |=> err_flag);

endmodule

bind dma_chan_regs dma_chan_regs_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_addr   (bus_addr),
   .bus_wen    (bus_wen),
   .bus_wdata  (bus_wdata),
   .bus_err_in (bus_err_in),
   .chan_req   (chan_req),
   .cfg_enable (cfg_enable),
   .cfg_mask   (cfg_mask),
   .master_en  (master_en),
   .sw_pulse   (sw_pulse),
   .err_flag   (err_flag)
);

// File: tb/tb_dma_chan_regs.sv
`timescale 1ns/1ps
module tb_dma_chan_regs;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_wen = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] periph_req = '0;
   logic [31:0] wait_stat = '0;
   logic [3:0]  engine_state = '0;
   logic        bus_err_in = 1'b0;
   logic [31:0] chan_req, cfg_enable, cfg_mask, cfg_burst, cfg_alt, cfg_prio;
   logic        master_en;
   logic [31:0] ctl_base;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   always #5 clk = ~clk;

   dma_chan_regs dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .periph_req(periph_req),
      .wait_stat(wait_stat), .engine_state(engine_state), .bus_err_in(bus_err_in),
      .chan_req(chan_req), .cfg_enable(cfg_enable), .cfg_mask(cfg_mask),
      .cfg_burst(cfg_burst), .cfg_alt(cfg_alt), .cfg_prio(cfg_prio),
      .master_en(master_en), .ctl_base(ctl_base)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // write: drive at negedge, commit on posedge, release 1 ns later
   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wen = 1'b1; bus_wdata = d;
      @(posedge clk);
      #1;
      bus_wen = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   function automatic logic [31:0] attr_port(int i);
      case (i)
         0: return cfg_burst;
         1: return cfg_mask;
         2: return cfg_enable;
         3: return cfg_alt;
         default: return cfg_prio;
      endcase
   endfunction

   logic [31:0] model [5];

   task automatic check_attrs(input string tag);
      logic [31:0] r;
      for (int j = 0; j < 5; j++) begin
         chk({tag, " port"}, attr_port(j), model[j]);
         rd(12'h018 + 12'(j*8), r);
         chk({tag, " read set-addr R4"}, r, model[j]);
         rd(12'h01C + 12'(j*8), r);
         chk({tag, " read clr-addr R4"}, r, model[j]);
      end
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      logic [31:0] pats [5];
      bit          is_set [5];
      logic [31:0] msk, en, pr, exp;

      for (int j = 0; j < 5; j++) model[j] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;

      // R1 reset state
      check_attrs("R1 reset");
      chk("R1 master", {31'b0, master_en}, 32'h0);
      chk("R1 ctl_base", ctl_base, 32'h0);
      chk("R1 chan_req", chan_req, 32'h0);
      rd(12'h04C, r);
      chk("R1 err flag", r, 32'h0);

      // R2 R3 sweep of every set/clear pair
      pats[0] = 32'h0000FFFF; is_set[0] = 1;
      pats[1] = 32'h00FF00F0; is_set[1] = 1;
      pats[2] = 32'h0F0F0F0F; is_set[2] = 0;
      pats[3] = 32'h80000001; is_set[3] = 1;
      pats[4] = 32'h3C3C0000; is_set[4] = 0;
      for (int i = 0; i < 5; i++) begin
         for (int p = 0; p < 5; p++) begin
            if (is_set[p]) begin
               wr(12'h018 + 12'(i*8), pats[p]);
               model[i] = model[i] | pats[p];
               check_attrs("R2 set");
            end else begin
               wr(12'h01C + 12'(i*8), pats[p]);
               model[i] = model[i] & ~pats[p];
               check_attrs("R3 clr");
            end
         end
      end

      // R4 software request register reads zero
      rd(12'h014, r);
      chk("R4 swreq read", r, 32'h0);

      // R5 master enable and status
      engine_state = 4'h9;
      wr(12'h004, 32'hFFFF_FFFF);
      rd(12'h004, r);
      chk("R5 config read", r, 32'h1);
      rd(12'h000, r);
      chk("R5 status", r, 32'h001F_0091);
      wr(12'h004, 32'h0000_0000);
      rd(12'h000, r);
      chk("R5 status master off", r, 32'h001F_0090);

      // R6 base pointers
      wr(12'h008, 32'h2000_17FF);
      rd(12'h008, r);
      chk("R6 ctl base", r, 32'h2000_1400);
      chk("R6 ctl base port", ctl_base, 32'h2000_1400);
      rd(12'h00C, r);
      chk("R6 alt base", r, 32'h2000_1600);
      wr(12'h00C, 32'h0);
      wr(12'h000, 32'hFFFF_FFFF);
      rd(12'h00C, r);
      chk("R6 alt base read-only", r, 32'h2000_1600);
      rd(12'h000, r);
      chk("R6 status read-only", r, 32'h001F_0090);

      // R11 wait status and unmapped
      wait_stat = 32'hA5A5_0F0F;
      rd(12'h010, r);
      chk("R11 wait status", r, 32'hA5A5_0F0F);
      rd(12'h040, r);
      chk("R11 unmapped", r, 32'h0);
      rd(12'h100, r);
      chk("R11 unmapped high", r, 32'h0);

      // R7 R9 qualification: all 8 combinations across channels
      msk = 32'hAAAA_AAAA; en = 32'hCCCC_CCCC; pr = 32'hF0F0_F0F0;
      wr(12'h024, 32'hFFFF_FFFF); wr(12'h020, msk);
      wr(12'h02C, 32'hFFFF_FFFF); wr(12'h028, en);
      for (int m = 0; m < 2; m++) begin
         wr(12'h004, 32'(m));
         for (int k = 0; k < 4; k++) begin
            logic [31:0] pk;
            pk = (k == 0) ? pr : (k == 1) ? ~pr : (k == 2) ? 32'hFFFF_FFFF : 32'h1234_5678;
            @(negedge clk);
            periph_req = pk;
            #1;
            exp = (m == 1) ? (pk & ~msk & en) : 32'h0;
            chk(m ? "R7 periph qualified" : "R9 master off", chan_req, exp);
         end
      end
      @(negedge clk);
      periph_req = '0;

      // R8 software request, masked channels included
      wr(12'h014, 32'hFFFF_0003);
      chk("R8 sw pulse cycle", chan_req, 32'hFFFF_0003 & en);
      @(posedge clk); #1;
      chk("R8 sw pulse ends", chan_req, 32'h0);
      wr(12'h014, 32'h0000_0002);
      chk("R8 sw masked channel", chan_req, 32'h0);
      wr(12'h014, 32'h0000_0008);
      chk("R8 sw masked enabled ch3", chan_req, 32'h0000_0008);
      // R9 sw request on disabled channel
      wr(12'h014, 32'h0000_0011);
      chk("R9 sw disabled ch0/ch4", chan_req, 32'h0000_0000 | (32'h11 & en));
      wr(12'h004, 32'h0);
      wr(12'h014, 32'hFFFF_FFFF);
      chk("R9 sw master off", chan_req, 32'h0);

      // R10 error flag
      @(negedge clk); bus_err_in = 1'b1;
      @(posedge clk); #1; bus_err_in = 1'b0;
      rd(12'h04C, r);
      chk("R10 err set", r, 32'h1);
      wr(12'h04C, 32'h0000_0000);
      rd(12'h04C, r);
      chk("R10 err zero write", r, 32'h1);
      wr(12'h04C, 32'h0000_0001);
      rd(12'h04C, r);
      chk("R10 err cleared", r, 32'h0);
      @(negedge clk);
      bus_addr = 12'h04C; bus_wen = 1'b1; bus_wdata = 32'h1; bus_err_in = 1'b1;
      @(posedge clk); #1;
      bus_wen = 1'b0; bus_err_in = 1'b0;
      rd(12'h04C, r);
      chk("R10 set wins", r, 32'h1);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule